// File: doc/BRIEF.md
# Burst address sequence generator

This block produces the address for a four-beat burst in a synchronous memory. On a rising clock edge where an address strobe is accepted, it captures a start address. The upper bits are held as a registered row address. The lowest two bits become the start offset of the burst.

After that, each cycle with the advance input high moves the burst one beat forward. A static mode input picks the order of the beats. In interleaved order, the offset is the start offset XOR the beat number. In linear order, the offset counts up by one modulo four.

There are two strobes. The processor strobe counts only when the primary chip enable is high. The controller strobe loads the address whatever the chip enable is. A strobe that arrives during a burst restarts the burst at once.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, the upper address output and the offset output are both zero.
- R2: When the controller strobe is high at a rising edge, the upper output becomes address bits [AW-1:2] in the next cycle and the offset becomes address bits [1:0]. The chip enable does not affect this.
- R3: A processor strobe at a rising edge loads the address in the same way as R2 when the chip enable is high. It is ignored when the chip enable is low: without advance, both outputs stay unchanged.
- R4: In interleaved mode (mode input low), the offset k advances after the load equals the start offset XOR (k mod 4).
- R5: In linear mode (mode input high), the offset k advances after the load equals (start offset + k) mod 4. Reaching the end of the burst never changes the upper output.
- R6: With no accepted strobe and advance low, both outputs hold their values.
- R7: An accepted strobe during a burst reloads the address and restarts the beat count at zero, even if advance is high in the same cycle.
- R8: After four advances with no strobe, the offset is back at the start offset.
- R9: When both strobes are high together, the address is loaded once, exactly as for a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | AW | Start address presented with a strobe |
| strobe_proc | input | 1 | Processor address strobe, qualified by chip enable |
| strobe_ctrl | input | 1 | Controller address strobe, unqualified |
| chip_en | input | 1 | Primary chip enable |
| advance | input | 1 | Steps the burst one beat |
| lin_mode | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_hi | output | AW-2 | Registered upper address |
| beat_off | output | 2 | Current two-bit burst offset |

## Verification
On every cycle, the assertions check the following:
- an accepted strobe captures the address and clears the beat count;
- a lone advance steps the count by one;
- the upper address moves only on a load;
- a processor strobe that lacks the chip enable leaves the state untouched.

The order of the offsets over a full burst needs the scenarios of the bench, which compare every cycle against a reference model. These scenarios cover both modes, the wrap back to the start offset, reloads in the middle of a burst, and two strobes arriving together.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Offset for beat k of a burst starting at 'start'.
  function automatic beat_t burst_offset(beat_t start, beat_t k, logic lin);
    beat_t r;
    if (lin) r = start + k;
    else     r = start ^ k;
    return r;
  endfunction
endpackage

// File: rtl/bseq_load_qual.sv
module bseq_load_qual (
  input  logic strobe_proc,
  input  logic strobe_ctrl,
  input  logic chip_en,
  output logic load_proc,
  output logic load_ctrl,
  output logic load
);
  assign load_proc = strobe_proc & chip_en;
  assign load_ctrl = strobe_ctrl;
  assign load      = load_proc | load_ctrl;
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  advance,
  output beat_t beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (load)    beat <= '0;
    else if (advance) beat <= beat + beat_t'(1);
  end

  // R7: a load restarts the beat count
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat == '0);
  // R4: a lone advance steps one beat, wrapping mod 4 (R8)
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> beat == beat_t'($past(beat) + 1));
  // R6: no load and no advance holds the count
  a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(beat));
endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
  import burst_pkg::*;
#(
  parameter int AW = 10,
  localparam int HW = AW - BEAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  output logic [HW-1:0] hi_q,
  output beat_t         start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
    end else if (load) begin
      hi_q    <= addr_in[AW-1:BEAT_W];
      start_q <= addr_in[BEAT_W-1:0];
    end
  end

  // R2: capture of the strobed address
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hi_q == $past(addr_in[AW-1:BEAT_W])) &&
             (start_q == $past(addr_in[BEAT_W-1:0])));
  // R5: the upper address only changes on a load
  a_r5_hi_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hi_q) && $stable(start_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int AW = 10,
  localparam int HW = AW - BEAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          strobe_proc,
  input  logic          strobe_ctrl,
  input  logic          chip_en,
  input  logic          advance,
  input  logic          lin_mode,
  output logic [HW-1:0] addr_hi,
  output logic [1:0]    beat_off
);
  logic  load, load_proc, load_ctrl;
  beat_t beat, start_q;

  bseq_load_qual u_qual (
    .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl), .chip_en(chip_en),
    .load_proc(load_proc), .load_ctrl(load_ctrl), .load(load)
  );

  bseq_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .beat(beat)
  );

  bseq_addr_reg #(.AW(AW)) u_areg (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
    .hi_q(addr_hi), .start_q(start_q)
  );

  assign beat_off = burst_offset(start_q, beat, lin_mode);

  // R3: processor strobe without chip enable changes nothing
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_proc && !chip_en && !strobe_ctrl && !advance && $stable(lin_mode))
      |=> $stable(addr_hi) && $stable(beat_off));
  // R2: controller strobe loads whatever the chip enable
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ctrl |=> beat_off == burst_offset($past(addr_in[1:0]), '0, lin_mode));
  // R6: idle cycle holds outputs while the mode stays put
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) ##1 $stable(lin_mode) |-> $stable(beat_off));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WATCHDOG = 5000;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_proc = 0, strobe_ctrl = 0, chip_en = 0, advance = 0, lin_mode = 0;
  logic [AW-3:0] addr_hi;
  logic [1:0]    beat_off;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_hi = 0, m_start = 0, m_k = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_proc(strobe_proc),
    .strobe_ctrl(strobe_ctrl), .chip_en(chip_en), .advance(advance),
    .lin_mode(lin_mode), .addr_hi(addr_hi), .beat_off(beat_off)
  );

  function automatic int exp_off();
    if (lin_mode) return (m_start + m_k) % 4;
    return m_start ^ m_k;
  endfunction

  task automatic check(string tag);
    int eo = exp_off();
    tests++;
    if (int'(addr_hi) != m_hi || int'(beat_off) != eo) begin
      fails++;
      $display("FAIL %s: hi=%0h off=%0d expected hi=%0h off=%0d",
               tag, addr_hi, beat_off, m_hi, eo);
    end
  endtask

  task automatic step(bit sp, bit sc, bit ce, bit adv, bit lin,
                      int addr, string tag);
    @(negedge clk);
    strobe_proc = sp; strobe_ctrl = sc; chip_en = ce; advance = adv;
    lin_mode = lin; addr_in = AW'(addr);
    @(posedge clk);
    if (sc || (sp && ce)) begin
      m_hi = addr >> 2; m_start = addr % 4; m_k = 0;
    end else if (adv) begin
      m_k = (m_k + 1) % 4;
    end
    #(CLK_PERIOD/4);
    check(tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R1");
    rst_n = 1;
    // R2: controller strobe with chip enable low
    step(0, 1, 0, 0, 0, 'h2B7, "R2");
    // R4: interleaved burst, R8 wrap back to start
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, "R4");
    check("R8");
    // R6: idle hold
    step(0, 0, 1, 0, 0, 'h3FF, "R6");
    step(0, 0, 0, 0, 0, 'h000, "R6");
    // R3: processor strobe gated off
    step(1, 0, 0, 0, 0, 'h155, "R3");
    // R3: processor strobe accepted
    step(1, 0, 1, 0, 1, 'h151, "R3");
    // R5: linear burst with wrap, upper bits fixed
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 'h0FF, "R5");
    // R7: reload mid-burst with advance high
    step(0, 0, 0, 1, 1, 0, "R5");
    step(1, 0, 1, 1, 1, 'h1A2, "R7");
    step(0, 0, 0, 1, 1, 0, "R5");
    step(0, 1, 0, 1, 0, 'h0C3, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, "R4");
    // R9: both strobes together
    step(1, 1, 1, 0, 0, 'h3E6, "R9");
    step(0, 0, 1, 1, 0, 0, "R9");
    step(0, 0, 0, 1, 1, 0, "R5");
    step(0, 0, 0, 0, 1, 0, "R6");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule